// File: doc/BRIEF.md
# Compare-Match Toggle Timer

This block is one up-counting timer channel running in periodic-toggle mode. Software writes a start value into a load register and a target into a compare register, then turns the channel on. The counter is cleared when the channel is enabled. On the first timer tick after that, it takes the start value. Every later tick adds one.

Each time the counter reaches the target, the block inverts its output pin and sets a sticky compare flag. The compare flag can raise an interrupt. A reload option puts the start value back on the tick after each match, so the pin toggles with a fixed period. Without reload, the counter keeps running. It wraps at its top value, and the wrap sets a sticky overflow flag that can raise a second interrupt.

Ticks come from one of two sources. One is an internal enable pulse at a fixed fraction of the system clock (half by default). The other is an external prescaler pulse input. The whole block runs in a single clock domain.

Top module: `toggle_timer`

## Requirements
- R1: The counter advances only while the enable bit (control bit 4) is 1 and the mode field (control bits 3:0) equals 4'b0010. With any other mode value, the counter holds.
- R2: A write to control (address 0) that sets the enable bit while it was 0 clears the counter to 0. The same write loads the output pin with the inversion bit (control bit 6).
- R3: On the first tick after enable, the counter takes the load register value (address 2). Every later tick increments it by one.
- R4: Control bit 7 selects the tick source. When it is 0, a tick occurs once every CLK_DIV system clocks. When it is 1, a tick is each cycle in which `presc_tick` is high. Without ticks, the counter holds.
- R5: When a tick makes the counter equal to the compare register (address 3), the output pin inverts and the compare flag (status bit 0, address 1) is set, in the same cycle as the counter update.
- R6: With reload mode (control bit 5) set, the tick after a match loads the load register value. With reload mode clear, counting continues by increment.
- R7: An increment from the all-ones value wraps the counter to 0 and sets the overflow flag (status bit 1).
- R8: Both flags are sticky and are cleared by writing 1 to their status bit. A flag event wins over a clear in the same cycle. `irq_cmp` is the compare flag ANDed with control bit 8. `irq_ovf` is the overflow flag ANDed with control bit 9.
- R9: Reading address 4 returns the current counter value at any time, without disturbing counting.
- R10: Clearing the enable bit stops the counter and freezes the output pin at their current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| presc_tick | input | 1 | External prescaler tick pulse |
| timer_out | output | 1 | Toggling output pin |
| irq_cmp | output | 1 | Compare interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
The bench builds the block with CNT_W = 8 and CLK_DIV = 2. The narrow counter puts a full wrap within a few hundred ticks, so overflow, a non-reload match after the wrap, and flag clearing all fall inside a short run. The halved tick rate keeps the alternating-cycle timing of the internal source visible. The prescaler path is driven with an irregular pulse pattern.

// File: rtl/tt_pkg.sv
package tt_pkg;

   typedef enum logic [2:0] {
      TT_A_CTRL = 3'd0,
      TT_A_STAT = 3'd1,
      TT_A_LOAD = 3'd2,
      TT_A_CMP  = 3'd3,
      TT_A_CNT  = 3'd4
   } tt_addr_e;

   localparam logic [3:0] TT_MODE_TOGGLE = 4'b0010;
   localparam int TT_CTRL_W = 10;
   localparam int TT_B_EN   = 4;
   localparam int TT_B_INV  = 6;
   localparam int TT_B_CMPF = 0;
   localparam int TT_B_OVFF = 1;

   // Packed MSB first: oie = bit 9 ... mode = bits 3:0
   typedef struct packed {
      logic       oie;
      logic       cie;
      logic       src;
      logic       inv;
      logic       reload;
      logic       en;
      logic [3:0] mode;
   } tt_ctrl_t;

endpackage

// File: rtl/tt_tick.sv
module tt_tick #(
   parameter int CLK_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_ext,
   input  logic presc_tick,
   output logic tick
);
   logic div_tick;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign div_tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(CLK_DIV);
         localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);
         logic [DW-1:0] ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          ph_q <= '0;
            else if (ph_q == LAST) ph_q <= '0;
            else                 ph_q <= ph_q + 1'b1;
         end
         assign div_tick = (ph_q == LAST);
      end
   endgenerate

   assign tick = src_ext ? presc_tick : div_tick;
endmodule

// File: rtl/tt_regs.sv
module tt_regs
   import tt_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cmp_evt,
   input  logic              ovf_evt,
   input  logic [CNT_W-1:0]  cnt_q,
   output tt_ctrl_t          ctrl_q,
   output logic [CNT_W-1:0]  load_q,
   output logic [CNT_W-1:0]  cmp_q,
   output logic              start,
   output logic              cmp_flag,
   output logic              ovf_flag
);
   tt_addr_e sel;
   logic     stat_wr;

   assign sel     = tt_addr_e'(bus_addr);
   assign stat_wr = bus_wr && (sel == TT_A_STAT);
   assign start   = bus_wr && (sel == TT_A_CTRL) && bus_wdata[TT_B_EN] && !ctrl_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
         cmp_q  <= '0;
      end else if (bus_wr) begin
         case (sel)
            TT_A_CTRL: ctrl_q <= tt_ctrl_t'(bus_wdata[TT_CTRL_W-1:0]);
            TT_A_LOAD: load_q <= bus_wdata[CNT_W-1:0];
            TT_A_CMP:  cmp_q  <= bus_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // Event has priority over a write-one clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_flag <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         if (cmp_evt)                                  cmp_flag <= 1'b1;
         else if (stat_wr && bus_wdata[TT_B_CMPF])     cmp_flag <= 1'b0;
         if (ovf_evt)                                  ovf_flag <= 1'b1;
         else if (stat_wr && bus_wdata[TT_B_OVFF])     ovf_flag <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         TT_A_CTRL: bus_rdata = DATA_W'(ctrl_q);
         TT_A_STAT: bus_rdata = DATA_W'({ovf_flag, cmp_flag});
         TT_A_LOAD: bus_rdata = DATA_W'(load_q);
         TT_A_CMP:  bus_rdata = DATA_W'(cmp_q);
         TT_A_CNT:  bus_rdata = DATA_W'(cnt_q);
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tt_core.sv
module tt_core #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             inv_init,
   input  logic             run,
   input  logic             tick,
   input  logic             reload_mode,
   input  logic [CNT_W-1:0] load_q,
   input  logic [CNT_W-1:0] cmp_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             pin_q,
   output logic             cmp_evt,
   output logic             ovf_evt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             first_q;
   logic             rel_q;
   logic             take_load;
   logic             adv;
   logic [CNT_W-1:0] nxt;

   assign take_load = first_q || rel_q;
   assign adv       = run && tick && !start;
   assign nxt       = take_load ? load_q : cnt_q + 1'b1;
   assign ovf_evt   = adv && !take_load && (cnt_q == CNT_MAX);
   assign cmp_evt   = adv && (nxt == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pin_q   <= 1'b0;
         first_q <= 1'b0;
         rel_q   <= 1'b0;
      end else if (start) begin
         cnt_q   <= '0;
         pin_q   <= inv_init;
         first_q <= 1'b1;
         rel_q   <= 1'b0;
      end else if (adv) begin
         cnt_q   <= nxt;
         first_q <= 1'b0;
         rel_q   <= cmp_evt && reload_mode;
         pin_q   <= pin_q ^ cmp_evt;
      end
   end
endmodule

// File: rtl/toggle_timer.sv
module toggle_timer
   import tt_pkg::*;
#(
   parameter int CNT_W   = 24,
   parameter int DATA_W  = 32,
   parameter int CLK_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              presc_tick,
   output logic              timer_out,
   output logic              irq_cmp,
   output logic              irq_ovf
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("toggle_timer: CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W < TT_CTRL_W) begin : g_bad_data
         $error("toggle_timer: DATA_W too narrow for control");
      end
      if (CLK_DIV < 1) begin : g_bad_div
         $error("toggle_timer: CLK_DIV must be at least 1");
      end
   endgenerate

   tt_ctrl_t         ctrl_q;
   logic [CNT_W-1:0] load_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start;
   logic             run;
   logic             tick;
   logic             cmp_evt;
   logic             ovf_evt;
   logic             cmp_flag;
   logic             ovf_flag;
   logic             inv_q;

   assign run   = ctrl_q.en && (ctrl_q.mode == TT_MODE_TOGGLE);
   assign inv_q = ctrl_q.inv;

   tt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_evt(cmp_evt),
      .ovf_evt(ovf_evt), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .load_q(load_q),
      .cmp_q(cmp_q), .start(start), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
   );

   tt_tick #(.CLK_DIV(CLK_DIV)) i_tick (
      .clk(clk), .rst_n(rst_n), .src_ext(ctrl_q.src),
      .presc_tick(presc_tick), .tick(tick)
   );

   tt_core #(.CNT_W(CNT_W)) i_core (
      .clk(clk), .rst_n(rst_n), .start(start), .inv_init(bus_wdata[TT_B_INV]),
      .run(run), .tick(tick), .reload_mode(ctrl_q.reload), .load_q(load_q),
      .cmp_q(cmp_q), .cnt_q(cnt_q), .pin_q(timer_out), .cmp_evt(cmp_evt),
      .ovf_evt(ovf_evt)
   );

   assign irq_cmp = cmp_flag && ctrl_q.cie;
   assign irq_ovf = ovf_flag && ctrl_q.oie;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             run,
   input logic             cmp_evt,
   input logic             ovf_evt,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] cmp_q,
   input logic             timer_out,
   input logic             inv_q,
   input logic             cmp_flag,
   input logic             ovf_flag
);
   // R1, R10: an idle channel keeps its count
   p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(cnt_q));

   // R2: enabling clears the count and seeds the pin
   p_start_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == '0 && timer_out == inv_q));

   // R5: a match flips the pin and raises the flag
   p_match_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_evt |=> (timer_out != $past(timer_out) && cmp_flag && cnt_q == $past(cmp_q)));

   // R5: pin moves only on a match or a start
   p_pin_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_evt && !start) |=> $stable(timer_out));

   // R7: wrap lands on zero and sets the overflow flag
   p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> (cnt_q == '0 && ovf_flag));
endmodule

bind toggle_timer tt_checker #(.CNT_W(CNT_W)) i_tt_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .run(run), .cmp_evt(cmp_evt),
   .ovf_evt(ovf_evt), .cnt_q(cnt_q), .cmp_q(cmp_q), .timer_out(timer_out),
   .inv_q(inv_q), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
);

// File: tb/test_toggle_timer.sv
module test_toggle_timer;
   localparam int CW  = 8;
   localparam int DW  = 32;
   localparam int DIV = 2;
   localparam logic [CW-1:0] MAXV = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = 3'd4;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          presc_tick = 1'b0;
   logic          timer_out, irq_cmp, irq_ovf;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    presc_en = 1'b0;
   int    pc = 0;
   string tag = "reset";

   always #10 clk = ~clk;

   toggle_timer #(.CNT_W(CW), .DATA_W(DW), .CLK_DIV(DIV)) i_toggle_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .presc_tick(presc_tick),
      .timer_out(timer_out), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reference model
   logic [9:0]    m_ctrl = '0;
   logic [CW-1:0] m_load = '0, m_cmp = '0, m_cnt = '0, nx;
   logic          m_pin = 0, m_first = 0, m_rel = 0, m_cf = 0, m_of = 0;
   logic          t, st, rn, ce, oe;
   int            m_phase = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_load = '0; m_cmp = '0; m_cnt = '0;
         m_pin = 0; m_first = 0; m_rel = 0; m_cf = 0; m_of = 0; m_phase = 0;
      end else begin
         t  = m_ctrl[7] ? presc_tick : (m_phase == DIV - 1);
         m_phase = (m_phase + 1) % DIV;
         st = bus_wr && bus_addr == 3'd0 && bus_wdata[4] && !m_ctrl[4];
         rn = m_ctrl[4] && m_ctrl[3:0] == 4'b0010;
         ce = 0; oe = 0;
         if (st) begin
            m_cnt = '0; m_pin = bus_wdata[6]; m_first = 1; m_rel = 0;
         end else if (rn && t) begin
            if (m_first || m_rel) nx = m_load;
            else begin
               nx = m_cnt + 1'b1;
               oe = (m_cnt == MAXV);
            end
            ce = (nx == m_cmp);
            m_first = 0;
            m_rel = ce && m_ctrl[5];
            m_cnt = nx;
            if (ce) m_pin = !m_pin;
         end
         if (ce) m_cf = 1;
         else if (bus_wr && bus_addr == 3'd1 && bus_wdata[0]) m_cf = 0;
         if (oe) m_of = 1;
         else if (bus_wr && bus_addr == 3'd1 && bus_wdata[1]) m_of = 0;
         if (bus_wr) begin
            case (bus_addr)
               3'd0: m_ctrl = bus_wdata[9:0];
               3'd2: m_load = bus_wdata[CW-1:0];
               3'd3: m_cmp  = bus_wdata[CW-1:0];
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({tag, " pin"}, timer_out, m_pin);
         check({tag, " irq_cmp"}, irq_cmp, m_cf & m_ctrl[8]);
         check({tag, " irq_ovf"}, irq_ovf, m_of & m_ctrl[9]);
         if (!bus_wr && bus_addr == 3'd4) check({tag, " R9 count"}, bus_rdata, 32'(m_cnt));
         if (!bus_wr && bus_addr == 3'd1) check({tag, " R8 status"}, bus_rdata, {30'd0, m_of, m_cf});
      end
   end

   always @(negedge clk) begin
      #1;
      presc_tick = presc_en && (pc % 3 != 1) && (pc % 7 != 2);
      pc++;
   end

   function automatic logic [31:0] mk(logic [3:0] mode, logic en, logic rel,
                                      logic inv, logic src, logic cie, logic oie);
      return {22'd0, oie, cie, src, inv, rel, en, mode};
   endfunction

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk); #1;
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 0; bus_addr = 3'd4;
   endtask

   task automatic rd_stat();
      @(negedge clk); #1; bus_addr = 3'd1;
      @(negedge clk); #1; bus_addr = 3'd4;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle(4);
      @(negedge clk); #1; rst_n = 1;
      @(negedge clk);
      check("reset pin", timer_out, 0);
      check("reset irq", {irq_cmp, irq_ovf}, 0);
      check("reset count", bus_rdata, 0);

      tag = "R2 R3 R5 R6 R8 reload";
      wr(3'd2, 10);
      wr(3'd3, 14);
      wr(3'd0, mk(4'b0010, 1, 1, 1, 0, 1, 0));
      check("R2 pin seeded from inversion bit", timer_out, 1);
      idle(80);
      rd_stat();
      wr(3'd1, 1);
      rd_stat();

      tag = "R10 disabled";
      wr(3'd0, mk(4'b0010, 0, 1, 1, 0, 1, 0));
      idle(20);

      tag = "R6 R7 free-run wrap";
      wr(3'd2, 250);
      wr(3'd3, 3);
      wr(3'd0, mk(4'b0010, 1, 0, 0, 0, 1, 1));
      idle(600);
      rd_stat();
      wr(3'd1, 3);
      rd_stat();

      tag = "R4 prescaler";
      wr(3'd0, 0);
      presc_en = 1;
      wr(3'd0, mk(4'b0010, 1, 1, 0, 1, 1, 0));
      idle(120);
      presc_en = 0;
      idle(20);

      tag = "R1 other mode";
      wr(3'd0, 0);
      wr(3'd0, mk(4'b0011, 1, 1, 0, 0, 1, 1));
      idle(30);
      tag = "R1 R3 mode switched on";
      wr(3'd0, mk(4'b0010, 1, 1, 0, 0, 1, 1));
      idle(40);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule